// File: doc/BRIEF.md
# Duplex Grid/Segment Dimming Timer

This block produces the time-multiplexed drive for a display with two grids sharing thirty segment lines. A prescaler turns an oscillator tick into a bit-time strobe. A frame counter steps once per bit time and splits each frame into two halves, the first for grid 1 and the second for grid 2. Inside each half the selected grid is lit for an on-time. A short dark gap precedes the on-time and a longer one follows it, so the two grids never overlap. While a grid is lit, the segment lines show the latched pattern that belongs to that grid. At all other times the segment lines are low. The grid lines are active low.

The on-time comes from one of three sources. In day mode it is always the largest allowed value. In night mode it is either an 11-bit digital code or an externally measured analog on-time. Each source is saturated to its own ceiling. The chosen on-time is captured only when a frame ends, so changing an input in the middle of a frame never shortens or stretches a pulse that is already running. A low test input overrides everything: every segment turns on and both grids turn on.

Top module: `duplex_dim_timer`

## Requirements
- R1: One bit time is `OSC_DIV` (default 4) asserted `osc_tick_i` cycles. After reset is released with `osc_tick_i` held high, `grid1_n_o` first goes low on the 24th clock edge, which is 6 bit times into the frame.
- R2: A frame is 4096 bit times. `grid1_n_o` may be low only in bit times 0..2047 and `grid2_n_o` only in bit times 2048..4095. Each grid lights 6 bit times after its half begins. With an on-time of N bit times, the dark stretch from the end of grid 1 to the start of grid 2 is 2048−N bit times.
- R3: When `night_i` is 0, the on-time is 2032 bit times per grid, whatever `dim_code_i`, `ana_sel_i` and `ana_len_i` hold.
- R4: When `night_i` is 1 and `ana_sel_i` is 0, the on-time is `dim_code_i` bit times. A code of 0 keeps both grids high for the whole frame.
- R5: A `dim_code_i` above 2032 yields an on-time of 2032 bit times (duty 2032/2048).
- R6: When `night_i` is 1 and `ana_sel_i` is 1, the on-time is `ana_len_i` bit times, saturated at 256 bit times.
- R7: The on-time is captured at the last bit time of a frame. An input change made while a grid is lit does not alter any pulse in the current frame. The change applies from the next frame onward.
- R8: Outside test mode, the two grid outputs are never low together, and `seg_o` is all zeros whenever both grids are high. During reset both grids are high.
- R9: While `grid1_n_o` is low, `seg_o` equals `seg_data_i[29:0]`. While `grid2_n_o` is low, `seg_o` equals `seg_data_i[59:30]`.
- R10: While `test_n_i` is 0, every bit of `seg_o` is 1 and both grid outputs are 0. This takes effect with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick_i | input | 1 | Oscillator period strobe |
| seg_data_i | input | 60 | Latched segment data; [29:0] for grid 1, [59:30] for grid 2 |
| night_i | input | 1 | 1 = night mode (dimmed), 0 = day mode (full) |
| ana_sel_i | input | 1 | In night mode, 1 selects the analog on-time |
| ana_len_i | input | 9 | Analog on-time in bit times |
| dim_code_i | input | 11 | Digital dimming code in bit times out of 2048 |
| test_n_i | input | 1 | Active-low lamp test |
| seg_o | output | 30 | Segment drive |
| grid1_n_o | output | 1 | Grid 1 drive, active low |
| grid2_n_o | output | 1 | Grid 2 drive, active low |

## Verification
Several properties are checked on every cycle by assertions. These cover grid exclusivity, dark segments while no grid is lit, the counter stepping only on bit strobes, the captured on-time holding between frame ends, and that captured value staying at or below its ceiling. Other behaviour can only be shown by the bench scenarios, which measure pulse lengths and gaps at the outputs. These scenarios cover the exact on-time for each source and each clamp, the 6-bit-time lead after reset, the per-grid segment selection, the mid-pulse code change that must not disturb the running frame, and the lamp-test override.

// File: rtl/dimtim_pkg.sv
package dimtim_pkg;

    // Default geometry of one frame half, in bit times
    localparam int DEF_HALF_BITS = 2048;
    localparam int DEF_PRE_GAP   = 6;
    localparam int DEF_POST_GAP  = 10;
    localparam int DEF_ANA_MAX   = 256;

    // Where the captured on-time comes from
    typedef enum logic [1:0] {
        SRC_FULL    = 2'd0,
        SRC_DIGITAL = 2'd1,
        SRC_ANALOG  = 2'd2
    } dim_src_e;

    // Saturating limit
    function automatic logic [15:0] sat16(input logic [15:0] v, input logic [15:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/dimtim_prescale.sv
module dimtim_prescale #(
    parameter int OSC_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    output logic bit_stb_o
);
    localparam int PW = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(OSC_DIV - 1);

    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    assign bit_stb_o = tick_i && (pre_q == LAST);

    generate
        if (OSC_DIV > 1) begin : g_rate
            // R1
            stb_spacing_chk: assert property (@(posedge clk) disable iff (rst)
                bit_stb_o |=> !bit_stb_o);
        end
    endgenerate

endmodule

// File: rtl/dimtim_frame.sv
module dimtim_frame #(
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_stb_i,
    output logic [FW-1:0] bit_cnt_o,
    output logic          frame_end_o
);
    logic [FW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (bit_stb_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bit_cnt_o   = cnt_q;
    assign frame_end_o = bit_stb_i && (&cnt_q);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_stb_i |=> $stable(cnt_q));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        bit_stb_i |=> cnt_q == FW'($past(cnt_q) + 1'b1));

endmodule

// File: rtl/dimtim_ontime.sv
module dimtim_ontime
    import dimtim_pkg::*;
#(
    parameter int HW      = 11,
    parameter int DIM_W   = 11,
    parameter int ANA_W   = 9,
    parameter int MAX_ON  = 2032,
    parameter int ANA_MAX = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             night_i,
    input  logic             ana_sel_i,
    input  logic [DIM_W-1:0] dim_code_i,
    input  logic [ANA_W-1:0] ana_len_i,
    output logic [HW-1:0]    on_len_o
);
    dim_src_e      src;
    logic [HW-1:0] nxt_len;
    logic [HW-1:0] len_q;

    always_comb begin
        if (!night_i)       src = SRC_FULL;
        else if (ana_sel_i) src = SRC_ANALOG;
        else                src = SRC_DIGITAL;

        case (src)
            SRC_DIGITAL: nxt_len = HW'(sat16(16'(dim_code_i), 16'(MAX_ON)));
            SRC_ANALOG:  nxt_len = HW'(sat16(16'(ana_len_i), 16'(ANA_MAX)));
            default:     nxt_len = HW'(MAX_ON);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= HW'(MAX_ON);
        end else if (load_i) begin
            len_q <= nxt_len;
        end
    end

    assign on_len_o = len_q;

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(len_q));

    // R5
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        len_q <= HW'(MAX_ON));

    // R3
    day_full_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !night_i) |=> len_q == HW'(MAX_ON));

endmodule

// File: rtl/dimtim_drive.sv
module dimtim_drive #(
    parameter int NSEG    = 30,
    parameter int HW      = 11,
    parameter int PRE_GAP = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW:0]       bit_cnt_i,
    input  logic [HW-1:0]     on_len_i,
    input  logic [2*NSEG-1:0] seg_data_i,
    input  logic              test_n_i,
    output logic [NSEG-1:0]   seg_o,
    output logic              grid1_n_o,
    output logic              grid2_n_o
);
    logic [HW:0] pos_x;
    logic [HW:0] lo_x;
    logic [HW:0] hi_x;
    logic        lit;
    logic        first_half;

    always_comb begin
        pos_x      = {1'b0, bit_cnt_i[HW-1:0]};
        lo_x       = (HW+1)'(PRE_GAP);
        hi_x       = lo_x + {1'b0, on_len_i};
        lit        = (pos_x >= lo_x) && (pos_x < hi_x);
        first_half = !bit_cnt_i[HW];

        if (!test_n_i) begin
            seg_o     = '1;
            grid1_n_o = 1'b0;
            grid2_n_o = 1'b0;
        end else begin
            if (!lit)           seg_o = '0;
            else if (first_half) seg_o = seg_data_i[NSEG-1:0];
            else                seg_o = seg_data_i[2*NSEG-1:NSEG];
            grid1_n_o = !(lit && first_half);
            grid2_n_o = !(lit && !first_half);
        end
    end

    // R8
    grid_excl_chk: assert property (@(posedge clk) disable iff (rst)
        test_n_i |-> (grid1_n_o || grid2_n_o));

    // R8
    seg_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (test_n_i && grid1_n_o && grid2_n_o) |-> (seg_o == '0));

endmodule

// File: rtl/duplex_dim_timer.sv
module duplex_dim_timer
    import dimtim_pkg::*;
#(
    parameter int NSEG      = 30,
    parameter int OSC_DIV   = 4,
    parameter int HALF_BITS = DEF_HALF_BITS,
    parameter int PRE_GAP   = DEF_PRE_GAP,
    parameter int POST_GAP  = DEF_POST_GAP,
    parameter int DIM_W     = 11,
    parameter int ANA_W     = 9,
    parameter int ANA_MAX   = DEF_ANA_MAX
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick_i,
    input  logic [2*NSEG-1:0] seg_data_i,
    input  logic              night_i,
    input  logic              ana_sel_i,
    input  logic [ANA_W-1:0]  ana_len_i,
    input  logic [DIM_W-1:0]  dim_code_i,
    input  logic              test_n_i,
    output logic [NSEG-1:0]   seg_o,
    output logic              grid1_n_o,
    output logic              grid2_n_o
);
    localparam int HW     = $clog2(HALF_BITS);
    localparam int FW     = HW + 1;
    localparam int MAX_ON = HALF_BITS - PRE_GAP - POST_GAP;

    logic          bit_stb;
    logic          frame_end;
    logic [FW-1:0] bit_cnt;
    logic [HW-1:0] on_len;

    dimtim_prescale #(.OSC_DIV(OSC_DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (osc_tick_i),
        .bit_stb_o(bit_stb)
    );

    dimtim_frame #(.FW(FW)) u_frame (
        .clk        (clk),
        .rst        (rst),
        .bit_stb_i  (bit_stb),
        .bit_cnt_o  (bit_cnt),
        .frame_end_o(frame_end)
    );

    dimtim_ontime #(
        .HW(HW), .DIM_W(DIM_W), .ANA_W(ANA_W),
        .MAX_ON(MAX_ON), .ANA_MAX(ANA_MAX)
    ) u_on (
        .clk       (clk),
        .rst       (rst),
        .load_i    (frame_end),
        .night_i   (night_i),
        .ana_sel_i (ana_sel_i),
        .dim_code_i(dim_code_i),
        .ana_len_i (ana_len_i),
        .on_len_o  (on_len)
    );

    dimtim_drive #(.NSEG(NSEG), .HW(HW), .PRE_GAP(PRE_GAP)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .bit_cnt_i (bit_cnt),
        .on_len_i  (on_len),
        .seg_data_i(seg_data_i),
        .test_n_i  (test_n_i),
        .seg_o     (seg_o),
        .grid1_n_o (grid1_n_o),
        .grid2_n_o (grid2_n_o)
    );

endmodule

// File: tb/tb_duplex_dim_timer.sv
module tb_duplex_dim_timer;
    localparam int CLK_P = 10;
    localparam int WDOG  = 195000;

    logic        clk = 0;
    logic        rst = 1;
    logic        osc_tick = 1;
    logic [59:0] seg_data;
    logic        night = 0;
    logic        ana_sel = 0;
    logic [8:0]  ana_len = '0;
    logic [10:0] dim_code = 11'd5;
    logic        test_n = 1;
    logic [29:0] seg;
    logic        g1_n, g2_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    duplex_dim_timer dut (
        .clk(clk), .rst(rst), .osc_tick_i(osc_tick), .seg_data_i(seg_data),
        .night_i(night), .ana_sel_i(ana_sel), .ana_len_i(ana_len),
        .dim_code_i(dim_code), .test_n_i(test_n),
        .seg_o(seg), .grid1_n_o(g1_n), .grid2_n_o(g2_n)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Measure one frame starting at the next grid 1 pulse; optionally change
    // the digital code after chg_at cycles of the grid 1 pulse.
    task automatic meas(input int chg_at, input logic [10:0] chg_code,
                        output int l1, output int gap, output int l2, output int bad);
        l1 = 0; gap = 0; l2 = 0; bad = 0;
        while (g1_n !== 1'b0) @(negedge clk);
        while (g1_n == 1'b0) begin
            if (l1 == chg_at) dim_code = chg_code;
            if (seg !== seg_data[29:0] || g2_n !== 1'b1) bad++;
            l1++;
            @(negedge clk);
        end
        while (g1_n == 1'b1 && g2_n == 1'b1) begin
            if (seg !== '0) bad++;
            gap++;
            @(negedge clk);
        end
        while (g2_n == 1'b0) begin
            if (seg !== seg_data[59:30] || g1_n !== 1'b1) bad++;
            l2++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_align();
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: dark during reset
        chk("R8 reset grids", {g1_n, g2_n}, 2'b11);
        chk("R8 reset segs", seg, 0);
        rst = 0;
        n = 0;
        while (g1_n) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk("R1 first grid1 edge", n, 24);
    endtask

    task automatic t_day();
        int l1, gp, l2, bad;
        meas(-1, 11'd0, l1, gp, l2, bad);
        chk("R3 day grid1 cycles", l1, 2032*4);
        chk("R3 day grid2 cycles", l2, 2032*4);
        chk("R2 gap grid1->grid2", gp, 16*4);
        chk("R9 segment select day", bad, 0);
    endtask

    task automatic t_clamp();
        int l1, gp, l2, bad;
        night = 1; dim_code = 11'd2047;
        meas(-1, 11'd0, l1, gp, l2, bad);
        chk("R5 clamp grid1", l1, 2032*4);
        chk("R5 clamp grid2", l2, 2032*4);
    endtask

    task automatic t_code();
        int l1, gp, l2, bad;
        seg_data = {30'h2AAA_5555, 30'h1234_5678};
        dim_code = 11'd100;
        meas(-1, 11'd0, l1, gp, l2, bad);
        chk("R4 code100 grid1", l1, 400);
        chk("R4 code100 grid2", l2, 400);
        chk("R2 gap code100", gp, (2048-100)*4);
        chk("R9 segment select night", bad, 0);
    endtask

    task automatic t_midframe();
        int l1, gp, l2, bad;
        meas(40, 11'd2000, l1, gp, l2, bad);
        chk("R7 running grid1 kept", l1, 400);
        chk("R7 running grid2 kept", l2, 400);
        chk("R7 running gap kept", gp, (2048-100)*4);
        meas(-1, 11'd0, l1, gp, l2, bad);
        chk("R7 next frame grid1", l1, 2000*4);
        chk("R4 code2000 grid2", l2, 2000*4);
    endtask

    task automatic t_analog();
        int l1, gp, l2, bad;
        ana_sel = 1; ana_len = 9'd300;
        meas(-1, 11'd0, l1, gp, l2, bad);
        chk("R6 analog clamp grid1", l1, 256*4);
        chk("R6 analog clamp grid2", l2, 256*4);
    endtask

    task automatic t_zero();
        int lows;
        ana_sel = 0; dim_code = 11'd0;
        repeat (8000) @(negedge clk);
        lows = 0;
        for (int i = 0; i < 16384; i++) begin
            if (!g1_n || !g2_n || seg !== '0) lows++;
            @(negedge clk);
        end
        chk("R4 code0 dark frame", lows, 0);
    endtask

    task automatic t_test();
        test_n = 0;
        #1;
        chk("R10 test segs", seg, 30'h3FFF_FFFF);
        chk("R10 test grids", {g1_n, g2_n}, 2'b00);
        @(negedge clk);
        chk("R10 test held", {seg, g1_n, g2_n}, {30'h3FFF_FFFF, 2'b00});
        test_n = 1;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < WDOG) begin
            @(posedge clk); cyc++;
        end
        errors++; checks++;
        $display("FAIL R1 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        seg_data = {30'h0F0F_0F0F, 30'h3333_CCCC};
        t_reset_align();
        t_day();
        t_clamp();
        t_code();
        t_midframe();
        t_analog();
        t_zero();
        t_test();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule